// File: doc/BRIEF.md
# Auxiliary Staging and Scratch Register File

This block adds a second small register resource to a microcoded processor's data path: a 16-bit staging register M and a bank of thirty-two 16-bit scratch registers S. Both only respond while the processor is running a task that is permitted to use the writable control store. In any other task, M and S keep their contents. They also leave the processor bus alone in those tasks.

M takes the ALU result in the same cycle that the main L register would be loaded. Data reaches the S bank only through M, copied without any shifting. The five-bit register-select field of the microinstruction addresses the bank. Two codes of the three-bit bus-source field either copy M into the selected S entry or place the selected entry on the processor bus.

The bus output feeds a wired-AND processor bus, so it idles at all ones. A read with select value 0 returns the live M value instead of entry 0. That leaves 31 usable scratch entries.

Top module: `aux_sreg_file`

## Requirements
- R1: After reset M and every S entry hold 0, so any read of the bank returns 0.
- R2: When `ram_task` and `load_l` are both 1 at a rising edge, M takes `alu_out`; the new value is visible from the next cycle.
- R3: When `ram_task` or `load_l` is 0 at a rising edge, M keeps its value.
- R4: When `ram_task` is 1 and `bus_src` equals 3'b100 at a rising edge, S entry `rsel` takes the value of M unchanged (no shift).
- R5: When an S write and an M load happen at the same edge, the S entry receives the M value held before that edge.
- R6: While `ram_task` is 1 and `bus_src` equals 3'b011, `s_bus` shows S entry `rsel` in the same cycle; with `rsel` equal to 0 it shows the current M instead.
- R7: `s_bus` is all ones whenever a read is not selected: `ram_task` is 0, or `bus_src` is any code other than 3'b011. This includes the S write code, so a write never pulls the bus to zero.
- R8: With `ram_task` at 0, the write code leaves every S entry unchanged; a later read shows the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ram_task | input | 1 | Current task may use M and S |
| load_l | input | 1 | Load-L bit of the microinstruction |
| alu_out | input | 16 | ALU result |
| rsel | input | 5 | Register-select field |
| bus_src | input | 3 | Bus-source field |
| s_bus | output | 16 | Value driven onto the wired-AND processor bus |

## Verification
The bench targets four corner cases:
- **Read with select 0.** A design that returned entry 0 here would show stale scratch data instead of M.
- **Write and M load in the same cycle.** A design that forwarded the fresh ALU value into S would store the wrong word.
- **Write code issued in a task without access.** A leaky enable would corrupt S, and the bench exposes this on a later read.
- **Bus level during a write.** A design that pulled the bus low during a write would drive zeros onto the wired-AND bus.

// File: rtl/auxs_pkg.sv
package auxs_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 5;
    localparam logic [2:0] BSRC_READ_S  = 3'b011;
    localparam logic [2:0] BSRC_WRITE_S = 3'b100;
endpackage

// File: rtl/auxs_stage.sv
module auxs_stage #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] m_q
);
    typedef struct packed { logic [DW-1:0] m; } st_t;
    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_en) st_d.m = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_q = st_q.m;

    // R2
    m_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> m_q == $past(din));
    // R3
    m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(m_q));
endmodule

// File: rtl/auxs_bank.sv
module auxs_bank #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;
    typedef struct packed { logic [DEPTH-1:0][DW-1:0] mem; } st_t;
    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.mem[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[addr];

    // R4
    s_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> st_q.mem[$past(addr)] == $past(wdata));
    // R8
    s_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q.mem));
endmodule

// File: rtl/auxs_readmux.sv
module auxs_readmux #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 5
) (
    input  logic          rd_en,
    input  logic [AW-1:0] rsel,
    input  logic [DW-1:0] s_val,
    input  logic [DW-1:0] m_val,
    output logic [DW-1:0] bus_o
);
    always_comb begin
        if (!rd_en)            bus_o = '1;
        else if (rsel == '0)   bus_o = m_val;
        else                   bus_o = s_val;
    end
endmodule

// File: rtl/aux_sreg_file.sv
module aux_sreg_file
    import auxs_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ram_task,
    input  logic          load_l,
    input  logic [DW-1:0] alu_out,
    input  logic [AW-1:0] rsel,
    input  logic [2:0]    bus_src,
    output logic [DW-1:0] s_bus
);
    logic          ld_en, wr_en, rd_en;
    logic [DW-1:0] m_val, s_val;

    assign ld_en = ram_task & load_l;
    assign wr_en = ram_task & (bus_src == BSRC_WRITE_S);
    assign rd_en = ram_task & (bus_src == BSRC_READ_S);

    auxs_stage #(.DW(DW)) u_stage (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .din(alu_out), .m_q(m_val)
    );

    auxs_bank #(.DW(DW), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .addr(rsel),
        .wdata(m_val), .rdata(s_val)
    );

    auxs_readmux #(.DW(DW), .AW(AW)) u_mux (
        .rd_en(rd_en), .rsel(rsel), .s_val(s_val), .m_val(m_val), .bus_o(s_bus)
    );

    // R7
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_task |-> s_bus == '1);
    // R6
    bus_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_task && bus_src == BSRC_READ_S && rsel == '0) |-> s_bus == m_val);
    // R5
    s_old_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ld_en) |=> u_bank.st_q.mem[$past(rsel)] == $past(m_val));
endmodule

// File: tb/aux_sreg_file_bench.sv
module aux_sreg_file_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ram_task = 0, load_l = 0;
    logic [15:0] alu_out = 0;
    logic [4:0]  rsel = 0;
    logic [2:0]  bus_src = 0;
    logic [15:0] s_bus;

    int checks = 0, errors = 0;
    logic [15:0] mm;
    logic [15:0] sm [32];

    always #2.5 clk = ~clk;

    aux_sreg_file u_aux_sreg_file (
        .clk(clk), .rst_n(rst_n), .ram_task(ram_task), .load_l(load_l),
        .alu_out(alu_out), .rsel(rsel), .bus_src(bus_src), .s_bus(s_bus)
    );

    function automatic logic [15:0] exp_bus(logic rt, logic [2:0] bs, logic [4:0] rs);
        if (!(rt && bs == 3'b011)) return 16'hFFFF;
        if (rs == 0) return mm;
        return sm[rs];
    endfunction

    task automatic step(input logic rt, input logic ld, input logic [15:0] alu,
                        input logic [4:0] rs, input logic [2:0] bs, input string tag);
        logic [15:0] e;
        @(negedge clk);
        ram_task = rt; load_l = ld; alu_out = alu; rsel = rs; bus_src = bs;
        #1;
        e = exp_bus(rt, bs, rs);
        checks++;
        if (s_bus !== e) begin
            errors++;
            $display("FAIL %s: s_bus=%h expected=%h (rt=%0b bs=%0d rs=%0d)", tag, s_bus, e, rt, bs, rs);
        end
        if (rt && bs == 3'b100) sm[rs] = mm;
        if (rt && ld) mm = alu;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        mm = 0;
        for (int i = 0; i < 32; i++) sm[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset contents read as zero
        step(1, 0, 0, 0, 3'b011, "R1");
        step(1, 0, 0, 7, 3'b011, "R1");
        step(1, 0, 0, 31, 3'b011, "R1");
        // R2: load then read M through select 0
        step(1, 1, 16'hA5C3, 0, 3'b000, "R7");
        step(1, 0, 0, 0, 3'b011, "R2");
        // R3: load blocked by load_l low or by task
        step(1, 0, 16'h1111, 0, 3'b000, "R3");
        step(0, 1, 16'h2222, 0, 3'b000, "R7");
        step(1, 0, 0, 0, 3'b011, "R3");
        // R4 / R7: write drives bus high, then read back
        step(1, 0, 0, 9, 3'b100, "R7");
        step(1, 0, 0, 9, 3'b011, "R4");
        // R5: write with simultaneous load stores old M
        step(1, 1, 16'h0F0F, 12, 3'b100, "R5");
        step(1, 0, 0, 12, 3'b011, "R5");
        step(1, 0, 0, 0, 3'b011, "R2");
        // R8: write code outside RAM task ignored
        step(0, 0, 0, 9, 3'b100, "R7");
        step(1, 0, 0, 9, 3'b011, "R8");
        // R6: select 0 returns M even after writing S0
        step(1, 0, 0, 0, 3'b100, "R7");
        step(1, 1, 16'h7E57, 0, 3'b000, "R7");
        step(1, 0, 0, 0, 3'b011, "R6");
        // R7: read code with task off
        step(0, 0, 0, 9, 3'b011, "R7");
        for (int i = 0; i < 2000; i++) begin
            logic       rt;
            logic [2:0] bs;
            rt = ($urandom_range(0, 3) != 0);
            case ($urandom_range(0, 3))
                0: bs = 3'b011;
                1: bs = 3'b100;
                default: bs = 3'($urandom_range(0, 7));
            endcase
            step(rt, 1'($urandom_range(0, 1)), 16'($urandom), 5'($urandom_range(0, 31)), bs,
                 (rt && bs == 3'b011) ? "R6" : "R7");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule